// File: doc/BRIEF.md
# Cyclic ADC Jump-Weight Output Corrector

This block is the per-converter digital back end of a cyclic analog-to-digital converter that resolves 1.5 bits in every bit-decision phase. Over one conversion it collects the two-bit sub-converter decision of each phase and turns the decisions into two output words. It uses only shift registers and adders.

The raw word gives every decision its ideal power-of-two weight. The corrected word does this only for the ten lower decisions. Each of the six most significant decisions instead contributes a measured jump height, and the code of the decision selects which measurement is used. The measurements come in as two banks of unsigned 16-bit weights, one taken at the positive comparator threshold and one at the negative threshold. The block copies both banks into shift registers at the start of a conversion, so a calibration engine may rewrite them while a conversion is running.

A conversion begins with a start pulse and then consumes sixteen decision strobes. The first of these decisions is the most significant. The last two decisions are extra resolution for measuring the errors. A one-cycle valid pulse marks the point where both words are final.

Top module: `cadcJumpCorrector`

## Requirements
- R1: After reset, rawWord and corrWord are zero, and outValid and codeFault are low.
- R2: Decision codes are decoded as 2'b00 = -1, 2'b01 = 0 and 2'b10 = +1. On each accepted strobe, rawWord becomes twice its previous value plus the decoded digit. After sixteen strobes it equals the sum of d(i)*2^(15-i), where i = 0 is the first decision, and it is held as an 18-bit two's-complement value.
- R3: The first six decisions of a conversion (k = 0..5) contribute to corrWord through measured weights. Weight k is taken from bits [16k+15:16k] of posWeights or negWeights, and the weights are unsigned. A +1 decision adds posWeights slot k, a -1 decision subtracts negWeights slot k, and a 0 decision adds nothing.
- R4: The last ten decisions add to corrWord with ideal weights, so the final decision has weight 1. corrWord is a 20-bit two's-complement value.
- R5: outValid is high for exactly one cycle, in the cycle that follows the clock edge that accepted the sixteenth strobe. Both words then hold their values until the next start.
- R6: A strobe is ignored if it arrives while no conversion is in progress, whether before any start or after a conversion has completed.
- R7: convStart clears both words and starts a new conversion, including in the middle of a conversion. A strobe in the same cycle as convStart is ignored.
- R8: Decision code 2'b11 is accumulated as +1 and sets codeFault. codeFault stays set until the next convStart or reset.
- R9: When every posWeights and negWeights slot k holds the ideal value 2^(15-k), corrWord equals rawWord.
- R10: The weights are sampled in the convStart cycle. Changes to posWeights or negWeights later in the same conversion do not affect corrWord.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| convStart | input | 1 | Start of a conversion: clears the words and loads the weights |
| cycleStrobe | input | 1 | Marks a valid decision in this cycle |
| decision | input | 2 | 1.5-bit sub-converter decision code |
| posWeights | input | 96 | Six unsigned 16-bit jump weights for +1 decisions, slot 0 in the low bits |
| negWeights | input | 96 | Six unsigned 16-bit jump weights for -1 decisions, slot 0 in the low bits |
| rawWord | output | 18 | Ideally weighted result, two's complement |
| corrWord | output | 20 | Jump-weight corrected result, two's complement |
| outValid | output | 1 | One-cycle pulse when both words are final |
| codeFault | output | 1 | Sticky flag: an illegal decision code 2'b11 was seen |

## Verification
The hardest situations to reach from the ports are a restart in the middle of a conversion whose start pulse coincides with a strobe, and a weight bank that changes while its conversion is still in flight. The stimulus aborts a conversion after five upper-bit strobes, holds a strobe carrying a different code high in the restart cycle, and then checks that only the following sixteen decisions count. A second scenario rewrites both weight banks right after the first strobe and expects the result computed from the banks present at start.

// File: rtl/cadcCorrPkg.sv
package cadcCorrPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // start of conversion: zero words, load weight shifters
    logic take;    // accept the present decision
    logic upper;   // the accepted decision is one of the calibrated positions
  } convCtl_t;

  // 1.5-bit decision code to signed digit; the illegal code folds to +1
  function automatic logic signed [1:0] decodeDigit(input logic [1:0] code);
    case (code)
      2'b00:   return -2'sd1;
      2'b01:   return 2'sd0;
      default: return 2'sd1;
    endcase
  endfunction

endpackage

// File: rtl/cadcCorrControl.sv
module cadcCorrControl
  import cadcCorrPkg::*;
#(
  parameter int NUM_PHASES = 16,
  parameter int NUM_CAL    = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     convStart,
  input  logic     cycleStrobe,
  output convCtl_t ctl,
  output logic     outValid
);
  localparam int PH_W = $clog2(NUM_PHASES);

  logic            busy;
  logic [PH_W-1:0] phase;
  logic            lastPhase;

  assign lastPhase = (phase == PH_W'(NUM_PHASES - 1));

  always_comb begin
    ctl.clear = convStart;
    ctl.take  = cycleStrobe && busy && !convStart;
    ctl.upper = (phase < PH_W'(NUM_CAL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      phase    <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.take && lastPhase;
      if (convStart) begin
        busy  <= 1'b1;
        phase <= '0;
      end else if (ctl.take) begin
        if (lastPhase) begin
          busy  <= 1'b0;
          phase <= '0;
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end

  // R5: the completion flag never lasts beyond one cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R5: completion implies the conversion has closed
  a_r5_valid_idle: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !busy);

  // R7: a start always arms a fresh conversion at phase zero
  a_r7_start_arms: assert property (@(posedge clk) disable iff (rst)
    convStart |=> (busy && phase == '0));

endmodule

// File: rtl/cadcCorrDatapath.sv
module cadcCorrDatapath
  import cadcCorrPkg::*;
#(
  parameter int NUM_PHASES = 16,
  parameter int NUM_CAL    = 6,
  parameter int CORR_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  convCtl_t                    ctl,
  input  logic [1:0]                  decision,
  input  logic [NUM_CAL*CORR_W-1:0]   posWeights,
  input  logic [NUM_CAL*CORR_W-1:0]   negWeights,
  output logic [NUM_PHASES+1:0]       rawWord,
  output logic [CORR_W+3:0]           corrWord,
  output logic                        codeFault
);
  localparam int RAW_W = NUM_PHASES + 2;
  localparam int LOW_W = NUM_PHASES - NUM_CAL + 2;
  localparam int COR_W = CORR_W + 4;
  localparam int BANK_W = NUM_CAL * CORR_W;

  logic [RAW_W-1:0]  rawAcc;
  logic [LOW_W-1:0]  lowAcc;
  logic [COR_W-1:0]  upSum;
  logic [BANK_W-1:0] posSh, negSh;
  logic              faultQ;

  logic signed [1:0] digit;
  logic [COR_W-1:0]  term;
  logic [COR_W-1:0]  posExt, negExt;

  always_comb begin
    digit  = decodeDigit(decision);
    posExt = {{(COR_W-CORR_W){1'b0}}, posSh[CORR_W-1:0]};
    negExt = {{(COR_W-CORR_W){1'b0}}, negSh[CORR_W-1:0]};
    if (digit == 2'sd1)       term = posExt;
    else if (digit == -2'sd1) term = ~negExt + COR_W'(1);
    else                      term = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawAcc <= '0;
      lowAcc <= '0;
      upSum  <= '0;
      posSh  <= '0;
      negSh  <= '0;
      faultQ <= 1'b0;
    end else if (ctl.clear) begin
      rawAcc <= '0;
      lowAcc <= '0;
      upSum  <= '0;
      posSh  <= posWeights;
      negSh  <= negWeights;
      faultQ <= 1'b0;
    end else if (ctl.take) begin
      rawAcc <= {rawAcc[RAW_W-2:0], 1'b0} + {{(RAW_W-2){digit[1]}}, digit};
      if (ctl.upper) begin
        upSum <= upSum + term;
        posSh <= posSh >> CORR_W;
        negSh <= negSh >> CORR_W;
      end else begin
        lowAcc <= {lowAcc[LOW_W-2:0], 1'b0} + {{(LOW_W-2){digit[1]}}, digit};
      end
      if (decision == 2'b11) faultQ <= 1'b1;
    end
  end

  assign rawWord   = rawAcc;
  assign corrWord  = upSum + {{(COR_W-LOW_W){lowAcc[LOW_W-1]}}, lowAcc};
  assign codeFault = faultQ;

  // R8: the illegal-code flag is cleared only by a start
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (faultQ && !ctl.clear) |=> faultQ);

  // R7: a start empties all accumulators
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> (rawAcc == '0 && lowAcc == '0 && upSum == '0));

  // R6: without an accepted strobe or a start the words do not move
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!ctl.clear && !ctl.take) |=> ($stable(rawAcc) && $stable(lowAcc) && $stable(upSum)));

  // R10: the weight banks only move on a start or an upper-bit decision
  a_r10_weights_frozen: assert property (@(posedge clk) disable iff (rst)
    (!ctl.clear && !(ctl.take && ctl.upper)) |=> ($stable(posSh) && $stable(negSh)));

endmodule

// File: rtl/cadcJumpCorrector.sv
module cadcJumpCorrector
  import cadcCorrPkg::*;
#(
  parameter int NUM_PHASES = 16,
  parameter int NUM_CAL    = 6,
  parameter int CORR_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       convStart,
  input  logic                       cycleStrobe,
  input  logic [1:0]                 decision,
  input  logic [NUM_CAL*CORR_W-1:0]  posWeights,
  input  logic [NUM_CAL*CORR_W-1:0]  negWeights,
  output logic [NUM_PHASES+1:0]      rawWord,
  output logic [CORR_W+3:0]          corrWord,
  output logic                       outValid,
  output logic                       codeFault
);
  convCtl_t ctl;

  cadcCorrControl #(
    .NUM_PHASES(NUM_PHASES),
    .NUM_CAL(NUM_CAL)
  ) uCtl (
    .clk(clk),
    .rst(rst),
    .convStart(convStart),
    .cycleStrobe(cycleStrobe),
    .ctl(ctl),
    .outValid(outValid)
  );

  cadcCorrDatapath #(
    .NUM_PHASES(NUM_PHASES),
    .NUM_CAL(NUM_CAL),
    .CORR_W(CORR_W)
  ) uDp (
    .clk(clk),
    .rst(rst),
    .ctl(ctl),
    .decision(decision),
    .posWeights(posWeights),
    .negWeights(negWeights),
    .rawWord(rawWord),
    .corrWord(corrWord),
    .codeFault(codeFault)
  );

endmodule

// File: tb/tb_cadcJumpCorrector.sv
module tb_cadcJumpCorrector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        convStart;
  logic        cycleStrobe;
  logic [1:0]  decision;
  logic [95:0] posWeights;
  logic [95:0] negWeights;
  logic [17:0] rawWord;
  logic [19:0] corrWord;
  logic        outValid;
  logic        codeFault;

  int vectors = 0;
  int misses  = 0;

  // slot 0 (first decision) in the low 16 bits
  localparam logic [95:0] IDEAL_W =
    {16'd1024, 16'd2048, 16'd4096, 16'd8192, 16'd16384, 16'd32768};
  localparam logic [95:0] POS_W =
    {16'd1010, 16'd2030, 16'd4120, 16'd8100, 16'd16500, 16'd33000};
  localparam logic [95:0] NEG_W =
    {16'd1030, 16'd2060, 16'd4080, 16'd8250, 16'd16300, 16'd32500};

  always #(CLK_PERIOD/2) clk = ~clk;

  cadcJumpCorrector dut (
    .clk(clk), .rst(rst), .convStart(convStart), .cycleStrobe(cycleStrobe),
    .decision(decision), .posWeights(posWeights), .negWeights(negWeights),
    .rawWord(rawWord), .corrWord(corrWord), .outValid(outValid),
    .codeFault(codeFault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int digitOf(input logic [1:0] c);
    if (c == 2'b00) return -1;
    if (c == 2'b01) return 0;
    return 1;
  endfunction

  // independent model of the requirements (R2, R3, R4)
  task automatic model(input logic [31:0] codes, input logic [95:0] pw,
                       input logic [95:0] nw, output int raw, output int corr);
    int low;
    raw = 0; corr = 0; low = 0;
    for (int i = 0; i < 16; i++) begin
      int d;
      d = digitOf(codes[2*i +: 2]);
      raw = raw * 2 + d;
      if (i < 6) begin
        if (d > 0) corr += int'(pw[16*i +: 16]);
        else if (d < 0) corr -= int'(nw[16*i +: 16]);
      end else begin
        low = low * 2 + d;
      end
    end
    corr += low;
  endtask

  task automatic startPulse(input logic [95:0] pw, input logic [95:0] nw);
    posWeights = pw; negWeights = nw;
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
  endtask

  task automatic feed(input logic [31:0] codes);
    for (int i = 0; i < 16; i++) begin
      cycleStrobe = 1'b1;
      decision = codes[2*i +: 2];
      @(negedge clk);
    end
    cycleStrobe = 1'b0;
  endtask

  // sampled one negedge after the edge that took the last strobe
  task automatic checkResult(input logic [31:0] codes, input logic [95:0] pw,
                             input logic [95:0] nw, input string tag);
    int er, ec;
    model(codes, pw, nw, er, ec);
    check(outValid === 1'b1, {tag, " R5 valid"}, int'(outValid), 1);
    check(int'($signed(rawWord)) == er, {tag, " R2 raw"}, int'($signed(rawWord)), er);
    check(int'($signed(corrWord)) == ec, {tag, " R3/R4 corr"}, int'($signed(corrWord)), ec);
    @(negedge clk);
    check(outValid === 1'b0, {tag, " R5 single pulse"}, int'(outValid), 0);
    check(int'($signed(rawWord)) == er, {tag, " R5 hold"}, int'($signed(rawWord)), er);
  endtask

  task automatic runConv(input logic [31:0] codes, input logic [95:0] pw,
                         input logic [95:0] nw, input string tag);
    startPulse(pw, nw);
    feed(codes);
    checkResult(codes, pw, nw, tag);
  endtask

  task automatic testReset();
    rst = 1'b1; convStart = 1'b0; cycleStrobe = 1'b0; decision = 2'b01;
    posWeights = '0; negWeights = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rawWord == '0, "R1 raw", int'(rawWord), 0);
    check(corrWord == '0, "R1 corr", int'(corrWord), 0);
    check(outValid == 1'b0, "R1 valid", int'(outValid), 0);
    check(codeFault == 1'b0, "R1 fault", int'(codeFault), 0);
  endtask

  task automatic testStrayStrobes();
    // R6: strobes before any start
    repeat (3) begin
      cycleStrobe = 1'b1; decision = 2'b10; @(negedge clk);
    end
    cycleStrobe = 1'b0;
    check(rawWord == '0, "R6 pre-start raw", int'(rawWord), 0);
    check(outValid == 1'b0, "R6 pre-start valid", int'(outValid), 0);
    runConv(32'h2648_A190, POS_W, NEG_W, "R6 base");
    // R6: strobes after completion leave the result unchanged
    begin
      int er, ec;
      model(32'h2648_A190, POS_W, NEG_W, er, ec);
      repeat (4) begin
        cycleStrobe = 1'b1; decision = 2'b00; @(negedge clk);
        check(outValid == 1'b0, "R6 post-done valid", int'(outValid), 0);
      end
      cycleStrobe = 1'b0;
      check(int'($signed(rawWord)) == er, "R6 post-done raw", int'($signed(rawWord)), er);
      check(int'($signed(corrWord)) == ec, "R6 post-done corr", int'($signed(corrWord)), ec);
    end
  endtask

  task automatic testIdeal();
    // R9: ideal weights make both words agree
    logic [31:0] pats [4] = '{32'hAAAA_AAAA, 32'h0000_0000, 32'h2648_A190, 32'h9862_10A4};
    foreach (pats[p]) begin
      runConv(pats[p], IDEAL_W, IDEAL_W, "R9 ideal");
      check(int'($signed(corrWord)) == int'($signed(rawWord)), "R9 corr==raw",
            int'($signed(corrWord)), int'($signed(rawWord)));
    end
  endtask

  task automatic testMeasured();
    logic [31:0] pats [5] = '{32'hAAAA_AAAA, 32'h0000_0000, 32'h5555_5555,
                              32'h2648_A190, 32'h9862_10A4};
    foreach (pats[p]) runConv(pats[p], POS_W, NEG_W, "R3 measured");
  endtask

  task automatic testRestart();
    // R7: abort after five upper strobes, restart with a coincident strobe
    startPulse(POS_W, NEG_W);
    repeat (5) begin
      cycleStrobe = 1'b1; decision = 2'b10; @(negedge clk);
    end
    convStart = 1'b1; cycleStrobe = 1'b1; decision = 2'b00;
    @(negedge clk);
    convStart = 1'b0; cycleStrobe = 1'b0;
    check(rawWord == '0, "R7 cleared", int'(rawWord), 0);
    feed(32'h9862_10A4);
    checkResult(32'h9862_10A4, POS_W, NEG_W, "R7 restart");
  endtask

  task automatic testWeightFreeze();
    // R10: banks rewritten after the first strobe must not matter
    startPulse(POS_W, NEG_W);
    for (int i = 0; i < 16; i++) begin
      cycleStrobe = 1'b1;
      decision = (i % 2 == 0) ? 2'b10 : 2'b00;
      @(negedge clk);
      if (i == 0) begin
        posWeights = IDEAL_W; negWeights = '0;
      end
    end
    cycleStrobe = 1'b0;
    checkResult(32'h2222_2222, POS_W, NEG_W, "R10 frozen");
  endtask

  task automatic testFault();
    // R8: code 11 counts as +1 and raises the sticky flag
    runConv(32'hFFFF_FFFF, POS_W, NEG_W, "R8 illegal");
    check(codeFault == 1'b1, "R8 flag set", int'(codeFault), 1);
    repeat (2) @(negedge clk);
    check(codeFault == 1'b1, "R8 flag held", int'(codeFault), 1);
    runConv(32'h5555_5555, POS_W, NEG_W, "R8 clean");
    check(codeFault == 1'b0, "R8 flag cleared", int'(codeFault), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testStrayStrobes();
    testIdeal();
    testMeasured();
    testRestart();
    testWeightFreeze();
    testFault();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule